// File: doc/BRIEF.md
# Line Timing Sequencer

This block plays back a programmed line table to produce the vertical and horizontal CCD clock pattern for one line of readout. Each table holds up to sixteen entries. An entry carries a dwell time in pixel clocks, a drive code for each of the two vertical phases, and a flag that lets the horizontal clocks run. The vertical drive code selects a low, mid or third-level high voltage at an external driver.

Four tables are stored. Software fills them through a write port. A start pulse, together with a 2-bit table select, launches playback of one table. The sequencer holds each entry's drive pattern for that entry's dwell count and then moves to the next entry. It stops when it meets an entry whose count is zero, or after the sixteenth entry. On stopping it raises a single-cycle done pulse. A typical use keeps a line-transfer table in one slot and a photodiode-transfer table in another. In the line-transfer table the two vertical phases overlap between low and mid, and the horizontal readout follows. In the photodiode-transfer table one phase is lifted to the high level.

Top module: `line_seq`

## Requirements
- R1: While reset is low, and in the cycle after it is released, v1_lvl and v2_lvl are 2'b00, hclk_en is 0 and done is 0. Reset also clears every stored entry to a zero count, so a table that has not been written since reset ends at once.
- R2: In the idle state, a start sampled high at a clock edge begins playback of the table chosen by tbl_sel. Entry 0 drives the outputs from the cycle that follows that edge.
- R3: Entries are played in increasing index order. Each entry with a nonzero count N drives its codes for exactly N consecutive cycles, with no gap between entries.
- R4: An entry with count 0 ends the table. In the cycle it is reached, the outputs are low and done is 0. In the next cycle done is 1, for exactly one cycle.
- R5: If all sixteen entries have nonzero counts, done is 1 in the cycle right after the last cycle of entry 15, for one cycle.
- R6: The vertical level codes are 2'b00 = low, 2'b01 = mid and 2'b10 = high. A stored code of 2'b11 is driven as 2'b00.
- R7: hclk_en equals the horizontal-enable bit of the entry being played, and is 0 when no entry is being played.
- R8: A start that arrives while a table is playing is ignored, together with its tbl_sel value. The running table continues unchanged.
- R9: When wr_en is high at a clock edge, the entry at (wr_tbl, wr_idx) takes the values wr_count, wr_v1, wr_v2 and wr_hen. A later playback of that table reproduces those values.
- R10: The four tables are independent. Writing one table does not change what another table plays.
- R11: When no table is playing, including the done cycle, both vertical outputs are low and hclk_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 2 | Table written |
| wr_idx | input | 4 | Entry index written |
| wr_count | input | 12 | Dwell count written (0 ends the table) |
| wr_v1 | input | 2 | Phase-1 level code written |
| wr_v2 | input | 2 | Phase-2 level code written |
| wr_hen | input | 1 | Horizontal enable bit written |
| start | input | 1 | Start request |
| tbl_sel | input | 2 | Table to play on start |
| v1_lvl | output | 2 | Phase-1 vertical level code |
| v2_lvl | output | 2 | Phase-2 vertical level code |
| hclk_en | output | 1 | Horizontal clock enable |
| done | output | 1 | One-cycle end-of-table pulse |

## Verification
The bench takes the sum of the dwell counts of the entries it wrote and uses it to compute where each result falls. After the start edge, entry k appears once the counts of entries 0 to k-1 have elapsed. The terminating cycle follows the last nonzero entry, and done follows one cycle after the terminating cycle. For a full sixteen-entry table, done falls in the cycle straight after the last dwell. The bench drives inputs on the falling edge and samples every cycle of each run on the falling edge, so each comparison lands on a fixed cycle offset from the start edge. This also shows that a start sent during a run does not shift any later cycle.

// File: rtl/line_seq_pkg.sv
// Package: shared level codes, state encoding and code sanitising for the
// line timing sequencer. Assumes 2-bit vertical drive codes.
package line_seq_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } vlevel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Map the unused code 2'b11 onto the low level.
    function automatic logic [1:0] legal_level(input logic [1:0] code);
        return (code == 2'b11) ? LVL_LOW : code;
    endfunction

endpackage

// File: rtl/seq_table_mem.sv
// Table store: N_TABLES banks of N_ENTRIES entries, each holding a dwell
// count, two vertical codes and a horizontal-enable bit. There is one
// synchronous write port and an asynchronous read port. Reset clears every
// entry. Assumes N_TABLES and N_ENTRIES are powers of two.
module seq_table_mem #(
    parameter int N_TABLES  = 4,
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 12,
    localparam int TBL_W    = $clog2(N_TABLES),
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TBL_W-1:0] wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [1:0]       wr_v1,
    input  logic [1:0]       wr_v2,
    input  logic             wr_hen,
    input  logic [TBL_W-1:0] rd_tbl,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_count,
    output logic [1:0]       rd_v1,
    output logic [1:0]       rd_v2,
    output logic             rd_hen
);

    logic [CNT_W-1:0] bank_count [N_TABLES];
    logic [1:0]       bank_v1    [N_TABLES];
    logic [1:0]       bank_v2    [N_TABLES];
    logic             bank_hen   [N_TABLES];

    for (genvar t = 0; t < N_TABLES; t++) begin : g_bank
        logic [CNT_W-1:0] count_q [N_ENTRIES];
        logic [1:0]       v1_q    [N_ENTRIES];
        logic [1:0]       v2_q    [N_ENTRIES];
        logic             hen_q   [N_ENTRIES];
        logic             sel_wr;

        assign sel_wr = wr_en && (wr_tbl == TBL_W'(t));

        // Clear the bank on reset; otherwise store the addressed entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < N_ENTRIES; e++) begin
                    count_q[e] <= '0;
                    v1_q[e]    <= '0;
                    v2_q[e]    <= '0;
                    hen_q[e]   <= 1'b0;
                end
            end else if (sel_wr) begin
                count_q[wr_idx] <= wr_count;
                v1_q[wr_idx]    <= wr_v1;
                v2_q[wr_idx]    <= wr_v2;
                hen_q[wr_idx]   <= wr_hen;
            end
        end

        assign bank_count[t] = count_q[rd_idx];
        assign bank_v1[t]    = v1_q[rd_idx];
        assign bank_v2[t]    = v2_q[rd_idx];
        assign bank_hen[t]   = hen_q[rd_idx];
    end

    // Select the active bank's entry.
    always_comb begin
        rd_count = bank_count[rd_tbl];
        rd_v1    = bank_v1[rd_tbl];
        rd_v2    = bank_v2[rd_tbl];
        rd_hen   = bank_hen[rd_tbl];
    end

endmodule

// File: rtl/seq_dwell_ctr.sv
// Dwell counter: counts cycles spent in the current entry and flags the
// last cycle of a dwell of length 'limit'. It wraps to zero on that cycle so
// the next entry starts with a fresh count. Assumes limit is nonzero
// whenever en is high.
module seq_dwell_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] elapsed_q;

    assign expire = en && (elapsed_q == (limit - CNT_W'(1)));

    // Advance the elapsed count, wrapping at the end of each dwell.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            elapsed_q <= '0;
        end else if (en) begin
            elapsed_q <= expire ? '0 : elapsed_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
// Playback control: latches the table on an idle start, steps the entry
// index when a dwell expires, and stops on a zero-count entry or after the
// final index, raising a one-cycle done. Outputs are low unless an entry
// with a nonzero count is being played. Assumes the read port of the table
// store is combinational.
module seq_ctrl
    import line_seq_pkg::*;
#(
    parameter int N_TABLES  = 4,
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 12,
    localparam int TBL_W    = $clog2(N_TABLES),
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TBL_W-1:0] tbl_sel,
    input  logic [CNT_W-1:0] ent_count,
    input  logic [1:0]       ent_v1,
    input  logic [1:0]       ent_v2,
    input  logic             ent_hen,
    input  logic             dwell_expire,
    output logic [TBL_W-1:0] rd_tbl,
    output logic [IDX_W-1:0] rd_idx,
    output logic             dwell_clr,
    output logic             dwell_en,
    output logic [1:0]       v1_lvl,
    output logic [1:0]       v2_lvl,
    output logic             hclk_en,
    output logic             done,
    output logic             running
);

    seq_state_e       state_q;
    logic [TBL_W-1:0] tbl_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             term;
    logic             active;
    logic             last_idx;

    assign running  = (state_q == ST_RUN);
    assign term     = running && (ent_count == '0);
    assign active   = running && !term;
    assign last_idx = (idx_q == IDX_W'(N_ENTRIES - 1));

    assign rd_tbl    = tbl_q;
    assign rd_idx    = idx_q;
    assign dwell_clr = !running;
    assign dwell_en  = active;
    assign done      = done_q;

    // Sequence state, table/index registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tbl_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        tbl_q   <= tbl_sel;
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (term) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (dwell_expire) begin
                        if (last_idx) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the entry's pattern while active, otherwise a quiet low state.
    always_comb begin
        v1_lvl  = active ? legal_level(ent_v1) : LVL_LOW;
        v2_lvl  = active ? legal_level(ent_v2) : LVL_LOW;
        hclk_en = active && ent_hen;
    end

endmodule

// File: rtl/line_seq.sv
// Line timing sequencer top: a table store, playback control and a dwell
// counter. It plays one of N_TABLES line tables on start and emits the
// vertical level codes, the horizontal clock enable and a done pulse. All
// state is reset synchronously by rst_n (active low).
module line_seq #(
    parameter int N_TABLES  = 4,
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 12,
    localparam int TBL_W    = $clog2(N_TABLES),
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TBL_W-1:0] wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [1:0]       wr_v1,
    input  logic [1:0]       wr_v2,
    input  logic             wr_hen,
    input  logic             start,
    input  logic [TBL_W-1:0] tbl_sel,
    output logic [1:0]       v1_lvl,
    output logic [1:0]       v2_lvl,
    output logic             hclk_en,
    output logic             done
);

    logic [TBL_W-1:0] act_tbl;
    logic [IDX_W-1:0] act_idx;
    logic [CNT_W-1:0] ent_count;
    logic [1:0]       ent_v1;
    logic [1:0]       ent_v2;
    logic             ent_hen;
    logic             dwell_clr;
    logic             dwell_en;
    logic             dwell_expire;
    logic             seq_running;

    seq_table_mem #(
        .N_TABLES (N_TABLES),
        .N_ENTRIES(N_ENTRIES),
        .CNT_W    (CNT_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tbl  (wr_tbl),
        .wr_idx  (wr_idx),
        .wr_count(wr_count),
        .wr_v1   (wr_v1),
        .wr_v2   (wr_v2),
        .wr_hen  (wr_hen),
        .rd_tbl  (act_tbl),
        .rd_idx  (act_idx),
        .rd_count(ent_count),
        .rd_v1   (ent_v1),
        .rd_v2   (ent_v2),
        .rd_hen  (ent_hen)
    );

    seq_ctrl #(
        .N_TABLES (N_TABLES),
        .N_ENTRIES(N_ENTRIES),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tbl_sel     (tbl_sel),
        .ent_count   (ent_count),
        .ent_v1      (ent_v1),
        .ent_v2      (ent_v2),
        .ent_hen     (ent_hen),
        .dwell_expire(dwell_expire),
        .rd_tbl      (act_tbl),
        .rd_idx      (act_idx),
        .dwell_clr   (dwell_clr),
        .dwell_en    (dwell_en),
        .v1_lvl      (v1_lvl),
        .v2_lvl      (v2_lvl),
        .hclk_en     (hclk_en),
        .done        (done),
        .running     (seq_running)
    );

    seq_dwell_ctr #(
        .CNT_W(CNT_W)
    ) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dwell_clr),
        .en    (dwell_en),
        .limit (ent_count),
        .expire(dwell_expire)
    );

endmodule

// File: rtl/line_seq_chk.sv
// Property checker for the line timing sequencer, bound into line_seq.
// Assumes rst_n is held low for at least one clock at power-up.
module line_seq_chk #(
    parameter int TBL_W = 2,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       v1_lvl,
    input logic [1:0]       v2_lvl,
    input logic             hclk_en,
    input logic             done,
    input logic             running,
    input logic [TBL_W-1:0] act_tbl,
    input logic [IDX_W-1:0] act_idx
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!running && $past(running))); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (v1_lvl == 2'b00 && v2_lvl == 2'b00 && !hclk_en)); // R11

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_lvl != 2'b11 && v2_lvl != 2'b11)); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> (act_tbl == $past(act_tbl))); // R8

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && act_idx != $past(act_idx))
            |-> (act_idx == $past(act_idx) + IDX_W'(1))); // R3

endmodule

bind line_seq line_seq_chk #(
    .TBL_W(TBL_W),
    .IDX_W(IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .v1_lvl (v1_lvl),
    .v2_lvl (v2_lvl),
    .hclk_en(hclk_en),
    .done   (done),
    .running(seq_running),
    .act_tbl(act_tbl),
    .act_idx(act_idx)
);

// File: tb/line_seq_tb.sv
// Self-checking bench for line_seq: loads tables, plays them and compares
// every output cycle against a model built from the bench's own copy of the
// written tables.
module line_seq_tb;

    localparam int NT = 4;
    localparam int NE = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_tbl = '0;
    logic [3:0]    wr_idx = '0;
    logic [CW-1:0] wr_count = '0;
    logic [1:0]    wr_v1 = '0;
    logic [1:0]    wr_v2 = '0;
    logic          wr_hen = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    tbl_sel = '0;
    logic [1:0]    v1_lvl;
    logic [1:0]    v2_lvl;
    logic          hclk_en;
    logic          done;

    int cnt_m [NT][NE];
    int v1_m  [NT][NE];
    int v2_m  [NT][NE];
    int hen_m [NT][NE];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    line_seq u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tbl  (wr_tbl),
        .wr_idx  (wr_idx),
        .wr_count(wr_count),
        .wr_v1   (wr_v1),
        .wr_v2   (wr_v2),
        .wr_hen  (wr_hen),
        .start   (start),
        .tbl_sel (tbl_sel),
        .v1_lvl  (v1_lvl),
        .v2_lvl  (v2_lvl),
        .hclk_en (hclk_en),
        .done    (done)
    );

    // Level code as driven: 2'b11 is driven low (R6).
    function automatic int lvl(int code);
        return (code == 3) ? 0 : code;
    endfunction

    task automatic chk(string req, int ev1, int ev2, int eh, int ed);
        n_chk++;
        if (int'(v1_lvl) != ev1 || int'(v2_lvl) != ev2 ||
            int'(hclk_en) != eh || int'(done) != ed) begin
            n_fail++;
            $display("FAIL %s: v1=%0d v2=%0d hen=%0d done=%0d, expected v1=%0d v2=%0d hen=%0d done=%0d",
                     req, v1_lvl, v2_lvl, hclk_en, done, ev1, ev2, eh, ed);
        end
    endtask

    // Write one entry (R9) and update the bench's copy.
    task automatic wr(int t, int i, int c, int a, int b, int h);
        wr_en    = 1'b1;
        wr_tbl   = 2'(t);
        wr_idx   = 4'(i);
        wr_count = CW'(c);
        wr_v1    = 2'(a);
        wr_v2    = 2'(b);
        wr_hen   = 1'(h);
        @(negedge clk);
        wr_en = 1'b0;
        cnt_m[t][i] = c;
        v1_m[t][i]  = a;
        v2_m[t][i]  = b;
        hen_m[t][i] = h;
    endtask

    // Play table t; optionally send a competing start at cycle 'inject' (R8).
    task automatic play(int t, int inject);
        int cyc;
        bit full;
        tbl_sel = 2'(t);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        tbl_sel = 2'((t + 1) % NT);
        cyc  = 0;
        full = 1'b1;
        for (int i = 0; i < NE; i++) begin
            if (cnt_m[t][i] == 0) begin
                full = 1'b0;
                break;
            end
            for (int k = 0; k < cnt_m[t][i]; k++) begin
                // R2/R3/R7: entry i holds its codes for its full dwell.
                chk((cyc == inject + 1) ? "R8" : "R3",
                    lvl(v1_m[t][i]), lvl(v2_m[t][i]), hen_m[t][i], 0);
                start = (cyc == inject);
                cyc++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        if (!full) begin
            chk("R4", 0, 0, 0, 0);   // terminating entry: quiet, no done yet
            @(negedge clk);
            chk("R4", 0, 0, 0, 1);   // done one cycle later
        end else begin
            chk("R5", 0, 0, 0, 1);   // done right after entry 15
        end
        @(negedge clk);
        chk("R11", 0, 0, 0, 0);      // single-cycle done, quiet afterwards
    endtask

    initial begin
        int lt_c[8]  = '{12, 1, 3, 30, 2, 30, 1, 0};
        int lt_v1[8] = '{1, 1, 0, 0, 0, 0, 1, 0};
        int lt_v2[8] = '{0, 1, 1, 1, 0, 0, 0, 0};
        int pd_c[8]  = '{1, 500, 6, 240, 1, 400, 1310, 0};
        int pd_v1[8] = '{0, 1, 1, 0, 0, 1, 0, 0};
        int pd_v2[8] = '{1, 1, 0, 2, 0, 0, 1, 0};

        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NE; i++) begin
                cnt_m[t][i] = 0; v1_m[t][i] = 0; v2_m[t][i] = 0; hen_m[t][i] = 0;
            end

        repeat (3) @(negedge clk);
        chk("R1", 0, 0, 0, 0);       // in reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, 0, 0, 0);       // after release
        play(0, -10);                // R1: unwritten table ends at once

        // Line-transfer table in slot 0; horizontal enable only in entry 5 (R7).
        for (int i = 0; i < 8; i++) wr(0, i, lt_c[i], lt_v1[i], lt_v2[i], (i == 5) ? 1 : 0);
        // Photodiode-transfer table in slot 1 with a high-level phase (R6).
        for (int i = 0; i < 8; i++) wr(1, i, pd_c[i], pd_v1[i], pd_v2[i], 0);
        // Full sixteen-entry table in slot 2 with every code, 2'b11 included (R5, R6).
        for (int i = 0; i < NE; i++) wr(2, i, (i % 5) + 1, i % 4, (i + 1) % 4, i % 2);

        play(0, 20);                 // R8: start during run is ignored
        play(1, -10);                // R2, R3
        play(2, 5);                  // R5
        play(3, -10);                // R10: slot 3 untouched by other writes

        // R9/R10: rewrite one entry of slot 0 and replay both slots.
        wr(0, 3, 7, 2, 1, 1);
        play(0, -10);
        play(2, -10);

        // Sweep of every code pair and enable bit through one entry (R6, R7, R9).
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int h = 0; h < 2; h++) begin
                    wr(3, 0, ((a + b + h) % 3) + 1, a, b, h);
                    wr(3, 1, 0, 0, 0, 0);
                    play(3, -10);
                end

        // R1: reset in the middle of a run silences outputs and clears tables.
        tbl_sel = 2'd1;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NE; i++) cnt_m[t][i] = 0;
        @(negedge clk);
        chk("R1", 0, 0, 0, 0);
        play(1, -10);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule